// File: doc/BRIEF.md
# Loadable Up/Down Counter With Terminal Reload

This block is a general-purpose synchronous counter built from identical 4-bit slices. Each slice counts up or down. It has a clear that acts at once, with no clock edge, a parallel load that is active low, an enable that is active low, and a carry output that is active low and flags the terminal count. A clear overrides everything. A deasserted enable freezes the slice, and the load is frozen with it. A load takes precedence over counting.

A parameter picks one of three arrangements of the slices:

- **Cascade.** The slices are chained into one wide counter that shares the clock and the clear. A higher slice steps only in the cycle in which every lower slice shows its terminal count.
- **Reload.** A single slice feeds its own carry back into its load. After 1111 it jumps to a preset start value instead of 0000.
- **Truncated.** A single slice detects a chosen top value and loads 0000 after it. This gives a short cycle, 0 to 12 by default.

An external load always has precedence over the forced load of the two restricted modes.

Top module: `updn_cnt`

## Requirements
- R1: While `clr` is 1 the count `q` is 0 at once, without waiting for a clock edge. It stays 0 until the first edge after `clr` returns to 0.
- R2: With `en_n`=0, `ld_n`=1 and `up`=1, every rising edge adds one to the count, modulo 2^(total width). Restricted modes are the exception, as R8 and R9 state.
- R3: With `en_n`=0, `ld_n`=1 and `up`=0, every rising edge subtracts one from the count, modulo 2^(total width). Restricted modes are the exception, as R8 and R9 state.
- R4: While `en_n`=1 the count does not change on an edge, even when `ld_n`=0.
- R5: With `en_n`=0 and `ld_n`=0, the next edge loads `din` into the count.
- R6: With `DOWN_ZERO_TC`=0, `co_n` is 0 exactly while every counting bit is 1. With `DOWN_ZERO_TC`=1 and `up`=0, `co_n` is 0 exactly while the count is all zeros.
- R7: In cascade mode, a slice above the lowest one changes on a counting edge only if every lower slice showed its terminal count. With `up`=1, the 8-bit count then passes through all 256 values in order.
- R8: In reload mode, with `en_n`=0 and `ld_n`=1, the edge after the count 1111 loads `PRESET` (default 6). Counting up, the cycle is therefore 6 through 15.
- R9: In truncated mode, with `en_n`=0 and `ld_n`=1, the edge after the count `TRUNC_TOP` (default 12) loads 0. Counting up, the cycle is 13 states, 0 through 12.
- R10: In the restricted modes, `ld_n`=0 loads `din[3:0]` even when the count sits at the value that would force a reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Clear, active high, asynchronous |
| up | input | 1 | 1 = count up, 0 = count down |
| en_n | input | 1 | Enable, active low; 1 holds everything |
| ld_n | input | 1 | Parallel load, active low, synchronous |
| din | input | SLICE_W*NSLICE | Load value; restricted modes use only the low slice |
| q | output | SLICE_W*NSLICE | Current count; upper bits are 0 in restricted modes |
| co_n | output | 1 | Carry out, active low, at the terminal count |

## Verification
Two pairs of functions can fall in the same cycle, and both are provoked on purpose.

- **External load against forced load.** The bench loads the restricted counters to their forcing value, 12 or 15. On the very next edge it asserts `ld_n` with a different value. The result must be the external value, not 0 or the preset.
- **Frozen enable against pending load or carry.** The bench asserts `ld_n` while `en_n` is high. It also toggles `en_n` while the lower cascade slice sits at 1111. The count must not move in either case.

A behavioural integer model judges every cycle for four instances: up cascade, down cascade with zero decode, reload and truncated.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

    typedef enum logic [1:0] {
        CM_CASCADE = 2'd0,
        CM_RELOAD  = 2'd1,
        CM_TRUNC   = 2'd2
    } cnt_mode_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } slice_op_e;

endpackage

// File: rtl/updn_cnt_slice.sv
module updn_cnt_slice
    import updn_cnt_pkg::*;
#(
    parameter int W            = 4,
    parameter bit DOWN_ZERO_TC = 1'b0
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         up,
    input  logic         en_n,
    input  logic         ld_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         co_n
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } slice_st_t;

    slice_st_t st_d, st_q;
    slice_op_e op;
    logic      term;

    // priority: enable gates everything, then load, then count
    always_comb begin
        if (en_n)       op = OP_HOLD;
        else if (!ld_n) op = OP_LOAD;
        else if (up)    op = OP_INC;
        else            op = OP_DEC;

        st_d = st_q;
        unique case (op)
            OP_HOLD: st_d.cnt = st_q.cnt;
            OP_LOAD: st_d.cnt = din;
            OP_INC:  st_d.cnt = st_q.cnt + ONE;
            OP_DEC:  st_d.cnt = st_q.cnt - ONE;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        if (DOWN_ZERO_TC && !up) term = (st_q.cnt == '0);
        else                     term = (st_q.cnt == ALL_ONES);
    end

    assign q    = st_q.cnt;
    assign co_n = ~term;

    assert_clear_R1: assert property (@(posedge clk) clr |-> (q == '0))
        else $error("slice not cleared");

    assert_inc_R2: assert property (@(posedge clk) disable iff (clr)
        (!en_n && ld_n && up) |=> (q == $past(q) + ONE))
        else $error("slice increment wrong");

    assert_dec_R3: assert property (@(posedge clk) disable iff (clr)
        (!en_n && ld_n && !up) |=> (q == $past(q) - ONE))
        else $error("slice decrement wrong");

    assert_hold_R4: assert property (@(posedge clk) disable iff (clr)
        en_n |=> $stable(q))
        else $error("slice moved while disabled");

    assert_load_R5: assert property (@(posedge clk) disable iff (clr)
        (!en_n && !ld_n) |=> (q == $past(din)))
        else $error("slice load wrong");

    assert_co_up_R6: assert property (@(posedge clk) disable iff (clr)
        (!co_n && !en_n && ld_n && up) |=> (q == '0))
        else $error("carry not at top of up range");

    generate
        if (DOWN_ZERO_TC) begin : g_dz_chk
            assert_co_dn_R6: assert property (@(posedge clk) disable iff (clr)
                (!co_n && !en_n && ld_n && !up) |=> (q == ALL_ONES))
                else $error("carry not at bottom of down range");
        end
    endgenerate

endmodule

// File: rtl/updn_cnt_steer.sv
module updn_cnt_steer
    import updn_cnt_pkg::*;
#(
    parameter cnt_mode_e MODE      = CM_RELOAD,
    parameter int        W         = 4,
    parameter int        PRESET    = 6,
    parameter int        TRUNC_TOP = 12
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en_n,
    input  logic         ld_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] q_cur,
    input  logic         co_n,
    output logic         sl_ld_n,
    output logic [W-1:0] sl_din
);

    localparam logic [W-1:0] PRE_V = W'(PRESET);
    localparam logic [W-1:0] TOP_V = W'(TRUNC_TOP);

    logic         force_ld;
    logic [W-1:0] force_val;

    generate
        if (MODE == CM_TRUNC) begin : g_trunc
            logic unused_co;
            assign unused_co = co_n;
            assign force_ld  = (q_cur == TOP_V);
            assign force_val = '0;

            assert_wrap_R9: assert property (@(posedge clk) disable iff (clr)
                (!en_n && ld_n && q_cur == TOP_V) |=> (q_cur == '0))
                else $error("truncated wrap missed");
        end else begin : g_reload
            assign force_ld  = ~co_n;
            assign force_val = PRE_V;

            assert_reload_R8: assert property (@(posedge clk) disable iff (clr)
                (!en_n && ld_n && !co_n) |=> (q_cur == PRE_V))
                else $error("preset reload missed");
        end
    endgenerate

    // external load wins over the forced one
    assign sl_ld_n = ld_n & ~force_ld;
    assign sl_din  = ld_n ? force_val : din;

    assert_ext_first_R10: assert property (@(posedge clk) disable iff (clr)
        (!en_n && !ld_n) |=> (q_cur == $past(din)))
        else $error("external load lost");

endmodule

// File: rtl/updn_cnt.sv
module updn_cnt
    import updn_cnt_pkg::*;
#(
    parameter cnt_mode_e MODE         = CM_CASCADE,
    parameter int        SLICE_W      = 4,
    parameter int        NSLICE       = 2,
    parameter int        PRESET       = 6,
    parameter int        TRUNC_TOP    = 12,
    parameter bit        DOWN_ZERO_TC = 1'b0
) (
    input  logic                      clk,
    input  logic                      clr,
    input  logic                      up,
    input  logic                      en_n,
    input  logic                      ld_n,
    input  logic [SLICE_W*NSLICE-1:0] din,
    output logic [SLICE_W*NSLICE-1:0] q,
    output logic                      co_n
);

    localparam int CW = SLICE_W * NSLICE;

    generate
        if (MODE == CM_CASCADE) begin : g_cascade
            // chain_n[i] low: all slices below i sit at terminal count
            logic [NSLICE:0] chain_n;
            assign chain_n[0] = 1'b0;

            for (genvar i = 0; i < NSLICE; i++) begin : g_sl
                logic               sl_en_n;
                logic [SLICE_W-1:0] sl_q;
                logic               sl_co_n;

                assign sl_en_n = en_n | (ld_n & chain_n[i]);

                updn_cnt_slice #(
                    .W            (SLICE_W),
                    .DOWN_ZERO_TC (DOWN_ZERO_TC)
                ) u_slice (
                    .clk  (clk),
                    .clr  (clr),
                    .up   (up),
                    .en_n (sl_en_n),
                    .ld_n (ld_n),
                    .din  (din[i*SLICE_W +: SLICE_W]),
                    .q    (sl_q),
                    .co_n (sl_co_n)
                );

                assign q[i*SLICE_W +: SLICE_W] = sl_q;
                assign chain_n[i+1] = chain_n[i] | sl_co_n;

                if (i > 0) begin : g_chk
                    assert_upper_gate_R7: assert property (@(posedge clk) disable iff (clr)
                        (!en_n && ld_n && chain_n[i]) |=> $stable(sl_q))
                        else $error("upper slice stepped without carry");
                end
            end

            assign co_n = chain_n[NSLICE];
        end else begin : g_restricted
            logic [SLICE_W-1:0] r_q;
            logic [SLICE_W-1:0] r_din;
            logic               r_co_n;
            logic               r_ld_n;
            logic               unused_din;

            assign unused_din = ^din;

            updn_cnt_steer #(
                .MODE      (MODE),
                .W         (SLICE_W),
                .PRESET    (PRESET),
                .TRUNC_TOP (TRUNC_TOP)
            ) u_steer (
                .clk     (clk),
                .clr     (clr),
                .en_n    (en_n),
                .ld_n    (ld_n),
                .din     (din[SLICE_W-1:0]),
                .q_cur   (r_q),
                .co_n    (r_co_n),
                .sl_ld_n (r_ld_n),
                .sl_din  (r_din)
            );

            updn_cnt_slice #(
                .W            (SLICE_W),
                .DOWN_ZERO_TC (DOWN_ZERO_TC)
            ) u_slice (
                .clk  (clk),
                .clr  (clr),
                .up   (up),
                .en_n (en_n),
                .ld_n (r_ld_n),
                .din  (r_din),
                .q    (r_q),
                .co_n (r_co_n)
            );

            assign q    = CW'(r_q);
            assign co_n = r_co_n;
        end
    endgenerate

endmodule

// File: tb/updn_cnt_tb.sv
`timescale 1ns/1ps
module updn_cnt_tb;
    import updn_cnt_pkg::*;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       en_n = 1'b1;
    logic       ld_n = 1'b1;
    logic       up_r = 1'b1;
    logic [7:0] din = '0;

    logic [7:0] q_c, q_d, q_r, q_t;
    logic       co_c, co_d, co_r, co_t;

    int    n_chk = 0;
    int    n_bad = 0;
    int    m_c = 0, m_d = 0, m_r = 0, m_t = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    updn_cnt #(.MODE(CM_CASCADE)) u_dut (
        .clk(clk), .clr(clr), .up(1'b1), .en_n(en_n), .ld_n(ld_n),
        .din(din), .q(q_c), .co_n(co_c));

    updn_cnt #(.MODE(CM_CASCADE), .DOWN_ZERO_TC(1'b1)) u_dut_dn (
        .clk(clk), .clr(clr), .up(1'b0), .en_n(en_n), .ld_n(ld_n),
        .din(din), .q(q_d), .co_n(co_d));

    updn_cnt #(.MODE(CM_RELOAD)) u_dut_rld (
        .clk(clk), .clr(clr), .up(up_r), .en_n(en_n), .ld_n(ld_n),
        .din(din), .q(q_r), .co_n(co_r));

    updn_cnt #(.MODE(CM_TRUNC)) u_dut_trc (
        .clk(clk), .clr(clr), .up(up_r), .en_n(en_n), .ld_n(ld_n),
        .din(din), .q(q_t), .co_n(co_t));

    function automatic int nxt_wide(int cur, bit dir_up);
        if (en_n)  return cur;
        if (!ld_n) return int'(din);
        return dir_up ? (cur + 1) % 256 : (cur + 255) % 256;
    endfunction

    function automatic int nxt_small(int cur, bit is_trunc);
        if (en_n)                 return cur;
        if (!ld_n)                return int'(din[3:0]);
        if (!is_trunc && cur == 15) return 6;
        if (is_trunc && cur == 12)  return 0;
        return up_r ? (cur + 1) % 16 : (cur + 15) % 16;
    endfunction

    always @(posedge clk or posedge clr) begin
        if (clr) begin
            m_c <= 0; m_d <= 0; m_r <= 0; m_t <= 0;
        end else begin
            m_c <= nxt_wide(m_c, 1'b1);
            m_d <= nxt_wide(m_d, 1'b0);
            m_r <= nxt_small(m_r, 1'b0);
            m_t <= nxt_small(m_t, 1'b1);
        end
    end

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("cascade q", int'(q_c), m_c);
        chk("down cascade q", int'(q_d), m_d);
        chk("reload q", int'(q_r), m_r);
        chk("trunc q", int'(q_t), m_t);
        // R6 carry decode
        chk("cascade co_n", int'(co_c), (m_c == 255) ? 0 : 1);
        chk("down cascade co_n", int'(co_d), (m_d == 0) ? 0 : 1);
        chk("reload co_n", int'(co_r), (m_r == 15) ? 0 : 1);
        chk("trunc co_n", int'(co_t), (m_t == 15) ? 0 : 1);
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tag = "R1 reset";
        cyc(2);
        clr = 1'b0;

        tag = "R4 hold over load";
        en_n = 1'b1; ld_n = 1'b0; din = 8'hA5;
        cyc(3);

        tag = "R2 R7 R8 R9 R6 full run";
        en_n = 1'b0; ld_n = 1'b1;
        cyc(260);

        tag = "R5 load";
        ld_n = 1'b0; din = 8'h3C;
        cyc(1);
        tag = "R10 load beats trunc wrap";
        din = 8'h05;
        cyc(1);
        tag = "R5 R10 load to 0F";
        din = 8'h0F;
        cyc(1);
        tag = "R10 load beats reload";
        din = 8'h08;
        cyc(1);
        ld_n = 1'b1;
        tag = "R2 after load";
        cyc(6);

        tag = "R4 R7 enable gaps";
        ld_n = 1'b0; din = 8'h1D;
        cyc(1);
        ld_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            en_n = (i % 3 == 0);
            cyc(1);
        end
        en_n = 1'b0;

        tag = "R3 R6 R8 R9 down";
        up_r = 1'b0;
        cyc(40);
        up_r = 1'b1;

        tag = "R1 async clear";
        @(negedge clk);
        compare_all();
        #3 clr = 1'b1;
        #2;
        chk("cascade q", int'(q_c), 0);
        chk("down cascade q", int'(q_d), 0);
        chk("reload q", int'(q_r), 0);
        chk("trunc q", int'(q_t), 0);
        cyc(2);
        clr = 1'b0;
        tag = "R2 R9 restart";
        cyc(20);

        finish_run();
    end

endmodule